// File: doc/BRIEF.md
# CAN Core Enable and Pin Polarity Control

This block sits between a CAN protocol core and the chip pins. It holds a 16-bit global configuration word that software writes and reads back over a plain register port. Three bits are implemented: a run enable, a transmit pin polarity and a receive pin polarity. The run enable starts and stops the protocol core. It gates the core clock, and while the core is stopped it holds the protocol state and both 8-bit error counters cleared. The configuration word and the message storage are never touched by that clear.

The polarity bits let the pins use either dominant-low or dominant-high signalling. On the core side, bit value 0 is always dominant. Each pin direction passes through one register stage, in which it is inverted or not according to the stored polarity. While the core is stopped, the transmit pin rests at the recessive level for the current polarity, and the core sees a recessive receive bit. The core loads new error counter values through strobes. The block exposes the counters read-only and forces them to zero whenever the core is not running.

Top module: `can_gcfg`

## Requirements
- R1: After reset the following hold: `cfg_rdata` reads 0, `core_run` is 0, `core_clk_en` is 0, `core_clr` is 1, `can_tx_pin` is 1, `core_rx_bit` is 1, and both error counters read 0.
- R2: A write with `cfg_wr` high stores `cfg_wdata` bit 0 (enable), bit 1 (transmit polarity) and bit 2 (receive polarity). These bits read back on `cfg_rdata` after that clock edge. Bits 15..3 always read 0 and writes to them are ignored.
- R3: After a write that sets the enable bit in a stopped block, `core_clk_en` is 1 right after the write edge while `core_clr` stays 1 and `core_run` stays 0. One edge later, `core_clr` falls to 0 and `core_run` rises to 1.
- R4: After a write that clears the enable bit in a running block, `core_run` falls to 0 and `core_clr` rises to 1 right after the write edge, while `core_clk_en` stays 1 for exactly one more edge and then falls. The polarity bits written with it read back unchanged.
- R5: While running, `can_tx_pin` one edge after sampling equals `core_tx_bit` XOR the transmit polarity. With polarity 0, core 0 (dominant) drives the pin 0. With polarity 1, it drives the pin 1.
- R6: While running, `core_rx_bit` one edge after sampling equals `can_rx_pin` XOR the receive polarity. With polarity 0, pin 0 is dominant. With polarity 1, pin 1 is dominant. Both are delivered to the core as 0.
- R7: While not running, `core_tx_bit` is ignored and `can_tx_pin` sits at the recessive level (NOT of the transmit polarity). `core_rx_bit` is held at 1, whatever `can_rx_pin` does.
- R8: While running, a high `txerr_load` or `rxerr_load` makes the matching counter output take `txerr_val` or `rxerr_val` after the edge. While `core_clr` is 1, both counters are forced to 0 at each edge and the load strobes have no effect.
- R9: A polarity change acts on the pin path one edge after the write edge: the pin register sampled at the write edge still uses the old polarity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Current configuration word, unimplemented bits 0 |
| core_tx_bit | input | 1 | Transmit bit from the protocol core, 0 = dominant |
| core_rx_bit | output | 1 | Receive bit to the protocol core, 0 = dominant |
| can_tx_pin | output | 1 | Transmit pin level after polarity |
| can_rx_pin | input | 1 | Receive pin level before polarity |
| core_run | output | 1 | Core is running |
| core_clk_en | output | 1 | Clock-gate enable for the core clock |
| core_clr | output | 1 | Holds core protocol state cleared |
| txerr_load | input | 1 | Load strobe for the transmit error counter |
| txerr_val | input | 8 | New transmit error counter value |
| rxerr_load | input | 1 | Load strobe for the receive error counter |
| rxerr_val | input | 8 | New receive error counter value |
| txerr_cnt | output | 8 | Transmit error counter, read-only |
| rxerr_cnt | output | 8 | Receive error counter, read-only |

## Verification
The hardest situation to reach is the single edge during a disable, when the clock gate is still open while the clear is already asserted. At that moment the counters still hold their last loaded values and clear only at the following edge. The stimulus first enables the core and loads nonzero counter values. It then writes a disable and samples at each of the next two edges, catching the one-cycle overlap and the delayed zeroing. A polarity flip is written while the core transmits a steady recessive bit, which exposes the one-edge lag of the pin register.

// File: rtl/can_gcfg_pkg.sv
package can_gcfg_pkg;
  localparam int CFG_W     = 16;
  localparam int BIT_EN    = 0;
  localparam int BIT_TXPOL = 1;
  localparam int BIT_RXPOL = 2;
  localparam logic [CFG_W-1:0] IMPL_MASK =
    (CFG_W'(1) << BIT_EN) | (CFG_W'(1) << BIT_TXPOL) | (CFG_W'(1) << BIT_RXPOL);
  localparam int ERR_W     = 8;
  localparam int ERR_N     = 2;

  typedef struct packed {
    logic rx_pol;
    logic tx_pol;
    logic en;
  } cfg_t;
endpackage

// File: rtl/gcfg_reg.sv
module gcfg_reg
  import can_gcfg_pkg::*;
#(
  parameter int W = CFG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  output cfg_t         cfg
);
  logic [W-1:0] word_q;
  logic [W-1:0] word_d;

  always_comb begin
    word_d = word_q;
    if (wr_en) begin
      word_d = wr_data & IMPL_MASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else begin
      word_q <= word_d;
    end
  end

  assign rd_data    = word_q;
  assign cfg.en     = word_q[BIT_EN];
  assign cfg.tx_pol = word_q[BIT_TXPOL];
  assign cfg.rx_pol = word_q[BIT_RXPOL];

  AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == ($past(wr_data) & IMPL_MASK)); // R2
  AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data & ~IMPL_MASK) == '0); // R2
endmodule

// File: rtl/gcfg_seq.sv
module gcfg_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_en_i,
  output logic run_o,
  output logic clk_en_o,
  output logic clr_o
);
  logic en_dly_q;
  logic en_dly_d;

  always_comb begin
    en_dly_d = cfg_en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_dly_q <= 1'b0;
    end else begin
      en_dly_q <= en_dly_d;
    end
  end

  assign clk_en_o = cfg_en_i | en_dly_q;
  assign run_o    = cfg_en_i & en_dly_q;
  assign clr_o    = ~run_o;

  AST_EN_CLK_BEFORE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_en_i) |-> clk_en_o && clr_o); // R3
  AST_EN_RUN_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en_i && $past(cfg_en_i) |-> run_o && !clr_o); // R3
  AST_DIS_CLK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_en_i) |-> clk_en_o && clr_o && !run_o); // R4
  AST_DIS_CLK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_en_i) ##1 !cfg_en_i |-> !clk_en_o); // R4
endmodule

// File: rtl/gcfg_pins.sv
module gcfg_pins (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic tx_pol_i,
  input  logic rx_pol_i,
  input  logic core_tx_i,
  input  logic pin_rx_i,
  output logic pin_tx_o,
  output logic core_rx_o
);
  logic tx_q, tx_d;
  logic rx_q, rx_d;
  logic tx_core_lvl;

  always_comb begin
    tx_core_lvl = run_i ? core_tx_i : 1'b1;
    tx_d        = tx_core_lvl ^ tx_pol_i;
    rx_d        = run_i ? (pin_rx_i ^ rx_pol_i) : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= 1'b1;
      rx_q <= 1'b1;
    end else begin
      tx_q <= tx_d;
      rx_q <= rx_d;
    end
  end

  assign pin_tx_o  = tx_q;
  assign core_rx_o = rx_q;

  AST_TX_RUN_POL: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |=> pin_tx_o == ($past(core_tx_i) ^ $past(tx_pol_i))); // R5
  AST_RX_RUN_POL: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |=> core_rx_o == ($past(pin_rx_i) ^ $past(rx_pol_i))); // R6
  AST_TX_IDLE_RECESSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> pin_tx_o == !$past(tx_pol_i)); // R7
  AST_RX_IDLE_RECESSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> core_rx_o); // R7
endmodule

// File: rtl/gcfg_errcnt.sv
module gcfg_errcnt
  import can_gcfg_pkg::*;
#(
  parameter int N = ERR_N,
  parameter int W = ERR_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr_i,
  input  logic [N-1:0]        load_i,
  input  logic [N-1:0][W-1:0] val_i,
  output logic [N-1:0][W-1:0] cnt_o
);
  for (genvar g = 0; g < N; g++) begin : g_cnt
    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_d;

    always_comb begin
      cnt_d = cnt_q;
      if (clr_i) begin
        cnt_d = '0;
      end else if (load_i[g]) begin
        cnt_d = val_i[g];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_d;
      end
    end

    assign cnt_o[g] = cnt_q;

    AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> cnt_o[g] == '0); // R8
    AST_CNT_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_i && load_i[g] |=> cnt_o[g] == $past(val_i[g])); // R8
  end
endmodule

// File: rtl/can_gcfg.sv
module can_gcfg
  import can_gcfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             core_tx_bit,
  output logic             core_rx_bit,
  output logic             can_tx_pin,
  input  logic             can_rx_pin,
  output logic             core_run,
  output logic             core_clk_en,
  output logic             core_clr,
  input  logic             txerr_load,
  input  logic [ERR_W-1:0] txerr_val,
  input  logic             rxerr_load,
  input  logic [ERR_W-1:0] rxerr_val,
  output logic [ERR_W-1:0] txerr_cnt,
  output logic [ERR_W-1:0] rxerr_cnt
);
  logic rst_s1_q, rst_s2_q;
  cfg_t cfg;
  logic run, clr;
  logic [ERR_N-1:0]            cnt_load;
  logic [ERR_N-1:0][ERR_W-1:0] cnt_val;
  logic [ERR_N-1:0][ERR_W-1:0] cnt_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  gcfg_reg #(.W(CFG_W)) u_reg (
    .clk     (clk),
    .rst_n   (rst_s2_q),
    .wr_en   (cfg_wr),
    .wr_data (cfg_wdata),
    .rd_data (cfg_rdata),
    .cfg     (cfg)
  );

  gcfg_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_s2_q),
    .cfg_en_i (cfg.en),
    .run_o    (run),
    .clk_en_o (core_clk_en),
    .clr_o    (clr)
  );

  gcfg_pins u_pins (
    .clk       (clk),
    .rst_n     (rst_s2_q),
    .run_i     (run),
    .tx_pol_i  (cfg.tx_pol),
    .rx_pol_i  (cfg.rx_pol),
    .core_tx_i (core_tx_bit),
    .pin_rx_i  (can_rx_pin),
    .pin_tx_o  (can_tx_pin),
    .core_rx_o (core_rx_bit)
  );

  assign cnt_load = {rxerr_load, txerr_load};
  assign cnt_val  = {rxerr_val, txerr_val};

  gcfg_errcnt #(.N(ERR_N), .W(ERR_W)) u_err (
    .clk    (clk),
    .rst_n  (rst_s2_q),
    .clr_i  (clr),
    .load_i (cnt_load),
    .val_i  (cnt_val),
    .cnt_o  (cnt_out)
  );

  assign txerr_cnt = cnt_out[0];
  assign rxerr_cnt = cnt_out[1];
  assign core_run  = run;
  assign core_clr  = clr;
endmodule

// File: tb/can_gcfg_bench.sv
module can_gcfg_bench;
  logic        clk;
  logic        rst_n;
  logic        cfg_wr;
  logic [15:0] cfg_wdata;
  logic [15:0] cfg_rdata;
  logic        core_tx_bit;
  logic        core_rx_bit;
  logic        can_tx_pin;
  logic        can_rx_pin;
  logic        core_run;
  logic        core_clk_en;
  logic        core_clr;
  logic        txerr_load;
  logic [7:0]  txerr_val;
  logic        rxerr_load;
  logic [7:0]  rxerr_val;
  logic [7:0]  txerr_cnt;
  logic [7:0]  rxerr_cnt;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // {tx_pol, rx_pol, core_tx, pin_rx, exp_pin_tx, exp_core_rx}
  localparam logic [5:0] VEC [0:7] = '{
    6'b0000_00, 6'b0011_11, 6'b1001_11, 6'b1010_00,
    6'b0101_00, 6'b0110_11, 6'b1100_11, 6'b1111_00
  };

  can_gcfg u_can_gcfg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .core_tx_bit(core_tx_bit), .core_rx_bit(core_rx_bit),
    .can_tx_pin(can_tx_pin), .can_rx_pin(can_rx_pin), .core_run(core_run),
    .core_clk_en(core_clk_en), .core_clr(core_clr), .txerr_load(txerr_load),
    .txerr_val(txerr_val), .rxerr_load(rxerr_load), .rxerr_val(rxerr_val),
    .txerr_cnt(txerr_cnt), .rxerr_cnt(rxerr_cnt)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    cfg_wr    = 1'b1;
    cfg_wdata = d;
    step();
    cfg_wr    = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_wdata = '0; core_tx_bit = 1'b1;
    can_rx_pin = 1'b1; txerr_load = 1'b0; txerr_val = '0;
    rxerr_load = 1'b0; rxerr_val = '0;
    repeat (5) step();
    rst_n = 1'b1;
    repeat (4) step();

    // R1 reset state
    chk("R1", "rdata", cfg_rdata, 16'h0000);
    chk("R1", "run", {15'b0, core_run}, 16'h0);
    chk("R1", "clk_en", {15'b0, core_clk_en}, 16'h0);
    chk("R1", "clr", {15'b0, core_clr}, 16'h1);
    chk("R1", "tx_pin", {15'b0, can_tx_pin}, 16'h1);
    chk("R1", "core_rx", {15'b0, core_rx_bit}, 16'h1);
    chk("R1", "txerr", {8'b0, txerr_cnt}, 16'h0);
    chk("R1", "rxerr", {8'b0, rxerr_cnt}, 16'h0);

    // R2 reserved bits ignored
    wr(16'hFFF8);
    chk("R2", "rsvd write", cfg_rdata, 16'h0000);

    // R3 enable sequence
    wr(16'h0001);
    chk("R2", "readback", cfg_rdata, 16'h0001);
    chk("R3", "clk_en first", {15'b0, core_clk_en}, 16'h1);
    chk("R3", "clr held", {15'b0, core_clr}, 16'h1);
    chk("R3", "run held", {15'b0, core_run}, 16'h0);
    step();
    chk("R3", "run up", {15'b0, core_run}, 16'h1);
    chk("R3", "clr down", {15'b0, core_clr}, 16'h0);

    // R5 R6 polarity table
    for (int i = 0; i < 8; i++) begin
      wr({13'b0, VEC[i][4], VEC[i][5], 1'b1});
      core_tx_bit = VEC[i][3];
      can_rx_pin  = VEC[i][2];
      step();
      chk("R5", "tx pin", {15'b0, can_tx_pin}, {15'b0, VEC[i][1]});
      chk("R6", "core rx", {15'b0, core_rx_bit}, {15'b0, VEC[i][0]});
    end

    // R9 polarity change lag
    wr(16'h0001);
    core_tx_bit = 1'b1;
    step();
    chk("R9", "tx pin before", {15'b0, can_tx_pin}, 16'h1);
    wr(16'h0003);
    chk("R9", "tx pin at write edge", {15'b0, can_tx_pin}, 16'h1);
    step();
    chk("R9", "tx pin after", {15'b0, can_tx_pin}, 16'h0);

    // R8 counter loads while running
    txerr_load = 1'b1; txerr_val = 8'h2A;
    rxerr_load = 1'b1; rxerr_val = 8'h81;
    step();
    txerr_load = 1'b0; rxerr_load = 1'b0;
    chk("R8", "txerr load", {8'b0, txerr_cnt}, 16'h002A);
    chk("R8", "rxerr load", {8'b0, rxerr_cnt}, 16'h0081);

    // R4 disable sequence, keep polarity bits
    core_tx_bit = 1'b0;
    can_rx_pin  = 1'b0;
    wr(16'h0006);
    chk("R4", "run down", {15'b0, core_run}, 16'h0);
    chk("R4", "clr up", {15'b0, core_clr}, 16'h1);
    chk("R4", "clk_en hold", {15'b0, core_clk_en}, 16'h1);
    chk("R4", "pol kept", cfg_rdata, 16'h0006);
    chk("R8", "txerr not yet cleared", {8'b0, txerr_cnt}, 16'h002A);
    step();
    chk("R4", "clk_en drop", {15'b0, core_clk_en}, 16'h0);
    chk("R8", "txerr cleared", {8'b0, txerr_cnt}, 16'h0);
    chk("R8", "rxerr cleared", {8'b0, rxerr_cnt}, 16'h0);

    // R7 idle pins: tx_pol=1 so recessive pin is 0, core_tx ignored
    chk("R7", "tx idle", {15'b0, can_tx_pin}, 16'h0);
    chk("R7", "rx idle", {15'b0, core_rx_bit}, 16'h1);
    can_rx_pin = 1'b1;
    step();
    chk("R7", "rx idle pin1", {15'b0, core_rx_bit}, 16'h1);

    // R8 loads ignored while stopped
    txerr_load = 1'b1; txerr_val = 8'h55;
    rxerr_load = 1'b1; rxerr_val = 8'hAA;
    step();
    txerr_load = 1'b0; rxerr_load = 1'b0;
    chk("R8", "txerr ignored", {8'b0, txerr_cnt}, 16'h0);
    chk("R8", "rxerr ignored", {8'b0, rxerr_cnt}, 16'h0);

    // R2 all-ones write keeps only implemented bits
    wr(16'hFFFF);
    chk("R2", "all ones", cfg_rdata, 16'h0007);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule